// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block turns single-word requests from a processor core into timed read and write cycles on an external memory bus. A request carries an address, write data, a direction bit and an optional indivisible read-modify-write flag. The block drives an address, an active-low read strobe, an active-low write strobe and a data-drive enable. It returns a one-clock completion pulse, with the captured word when the cycle was a read.

Every cycle lasts at least a programmed number of wait states. A transfer-acknowledge input can stretch a cycle past that minimum by any amount. The cycle then ends one clock after the acknowledge is first seen high. A cycle programmed with zero wait states always takes one clock, whatever the acknowledge does.

A read-modify-write request runs as a read, then one idle turnaround clock, then a write of the supplied data to the same address. This acts as an atomic exchange. A lock output covers the whole sequence. A software hold bit can also force the lock output high.

Top module: `xbus_seq`

## Requirements
- R1: While reset is held and right after it, both strobes are high, the address is zero, `busDataOe`, `busLock` and `done` are low, `reqReady` is high, and the minimum wait count is zero.
- R2: With W ≥ 1 programmed wait states and the acknowledge held high, a cycle holds its strobe low for exactly W+1 clocks. A cycle is never shorter than W+1 clocks.
- R3: Suppose W ≥ 1 and the acknowledge first goes high in strobe clock A, with A ≥ W. The strobe is then low for exactly A+1 clocks. A cycle with no acknowledge never ends.
- R4: With W = 0, a cycle holds its strobe low for exactly one clock, whether the acknowledge is high or low.
- R5: The acknowledge has no effect while no cycle is in progress. An acknowledge seen before a cycle is accepted does not shorten that cycle. `reqReady` is high exactly while idle, and a request is accepted on a clock edge where `reqValid` and `reqReady` are both high.
- R6: `busRdN` and `busWrN` are never low together, and they are low only in a data phase. `busDataOe` is high exactly while `busWrN` is low, and `busDataOut` then carries the request's write data.
- R7: Read data is sampled from `busDataIn` on the edge that ends the read strobe. `done` is high for exactly one clock, which is the clock after the last strobe clock. `rdData` holds the sampled word in that clock.
- R8: A request with `reqRmw` = 1 (where `reqWrite` is ignored) reads, spends one clock with both strobes high and the address held, then writes `reqWdata` to the same address. `busLock` rises with the first read clock, stays high through the turnaround clock and the write, and falls in the `done` clock. That `done` carries the word that was read.
- R9: While the lock-hold bit is 1, `busLock` is high in every clock, including idle clocks.
- R10: A write to the configuration (`cfgWe` = 1) takes effect on the next edge. A cycle uses the wait count that was in force when it was accepted, so a change made during a cycle affects only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Load the configuration register |
| cfgWait | input | WAIT_W | Minimum wait states per cycle |
| cfgLockHold | input | 1 | Software lock-hold bit |
| reqValid | input | 1 | Core request present |
| reqReady | output | 1 | Sequencer idle, request can be accepted |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRmw | input | 1 | Indivisible read-then-write to one address |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Request write data |
| done | output | 1 | One-clock completion pulse |
| rdData | output | DATA_W | Captured read word |
| busAddr | output | ADDR_W | External address, zero when idle |
| busRdN | output | 1 | Read strobe, active low |
| busWrN | output | 1 | Write strobe, active low |
| busDataOe | output | 1 | Drive enable for the external data lines |
| busDataOut | output | DATA_W | Write data toward the bus |
| busDataIn | input | DATA_W | Read data from the bus |
| busAck | input | 1 | Transfer acknowledge, active high, already synchronous |
| busLock | output | 1 | Bus lock, active high |

## Verification
The embedded properties check, on every clock, the things that are local in time:
- the strobes never overlap, and the drive enable matches the write strobe;
- `done` is a single-clock pulse;
- a data phase never ends before its wait count;
- a zero-wait phase lasts one clock;
- the lock stays high through the turnaround and falls only with `done`;
- an idle sequencer with no request stays idle whatever the acknowledge does.

Other behaviours need whole scenarios and the bench's reference model, which is compared on every clock:
- the exact stretched length when the acknowledge comes late;
- the wait count being taken at acceptance rather than read live;
- the read-then-write data flow of an exchange;
- the lock-hold override.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic load;
    logic capture;
    logic drive;
    logic wrPhase;
    logic addrOn;
  } dp_strobe_t;
endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              cfgLockHold,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqRmw,
  input  logic              busAck,
  output logic              reqReady,
  output logic              done,
  output logic              busLock,
  output dp_strobe_t        strb
);
  seq_state_t        stateQ;
  logic [WAIT_W-1:0] waitQ, cntQ, cfgWaitQ;
  logic              ackSeenQ, wrPhaseQ, rmwQ, lockQ, doneQ, holdQ;
  logic              accept, finish, inData;

  assign inData = (stateQ == ST_DATA);
  assign accept = (stateQ == ST_IDLE) && reqValid;
  assign finish = inData && (cntQ >= waitQ) && ((waitQ == '0) || ackSeenQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgWaitQ <= '0;
      holdQ    <= 1'b0;
    end else if (cfgWe) begin
      cfgWaitQ <= cfgWait;
      holdQ    <= cfgLockHold;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      waitQ    <= '0;
      cntQ     <= '0;
      ackSeenQ <= 1'b0;
      wrPhaseQ <= 1'b0;
      rmwQ     <= 1'b0;
      lockQ    <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (stateQ)
        ST_IDLE: begin
          if (accept) begin
            stateQ   <= ST_DATA;
            waitQ    <= cfgWaitQ;
            cntQ     <= '0;
            ackSeenQ <= 1'b0;
            rmwQ     <= reqRmw;
            wrPhaseQ <= reqWrite && !reqRmw;
            lockQ    <= reqRmw;
          end
        end
        ST_DATA: begin
          if (finish) begin
            if (rmwQ && !wrPhaseQ) begin
              stateQ <= ST_GAP;
            end else begin
              stateQ <= ST_IDLE;
              doneQ  <= 1'b1;
              lockQ  <= 1'b0;
            end
          end else begin
            if (cntQ < waitQ) cntQ <= cntQ + 1'b1;
            ackSeenQ <= ackSeenQ | busAck;
          end
        end
        ST_GAP: begin
          stateQ   <= ST_DATA;
          wrPhaseQ <= 1'b1;
          cntQ     <= '0;
          ackSeenQ <= 1'b0;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign reqReady     = (stateQ == ST_IDLE);
  assign done         = doneQ;
  assign busLock      = lockQ | holdQ;
  assign strb.load    = accept;
  assign strb.capture = finish && !wrPhaseQ;
  assign strb.drive   = inData;
  assign strb.wrPhase = wrPhaseQ;
  assign strb.addrOn  = (stateQ != ST_IDLE);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  // R2
  min_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inData && (cntQ < waitQ)) |=> (stateQ == ST_DATA));
  // R4
  zero_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inData && (waitQ == '0)) |=> (stateQ != ST_DATA));
  // R8
  gap_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_GAP) |-> lockQ);
  // R8
  lock_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockQ) |-> doneQ);
  // R5
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_IDLE) && !reqValid) |=> (stateQ == ST_IDLE));
endmodule

// File: rtl/xbus_dp.sv
module xbus_dp
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRdN,
  output logic              busWrN,
  output logic              busDataOe,
  output logic [DATA_W-1:0] busDataOut
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.capture) rdataQ <= busDataIn;
    end
  end

  assign busAddr    = strb.addrOn ? addrQ : '0;
  assign busRdN     = !(strb.drive && !strb.wrPhase);
  assign busWrN     = !(strb.drive && strb.wrPhase);
  assign busDataOe  = strb.drive && strb.wrPhase;
  assign busDataOut = wdataQ;
  assign rdData     = rdataQ;

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~busRdN, ~busWrN}));
  // R6
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdN && !strb.load) |=> ($stable(busAddr) || busAddr == '0));
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 24,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              cfgLockHold,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqRmw,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRdN,
  output logic              busWrN,
  output logic              busDataOe,
  output logic [DATA_W-1:0] busDataOut,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busAck,
  output logic              busLock
);
  dp_strobe_t strb;

  xbus_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWait(cfgWait),
    .cfgLockHold(cfgLockHold), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqRmw(reqRmw), .busAck(busAck), .reqReady(reqReady), .done(done),
    .busLock(busLock), .strb(strb)
  );

  xbus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busDataIn(busDataIn), .rdData(rdData),
    .busAddr(busAddr), .busRdN(busRdN), .busWrN(busWrN),
    .busDataOe(busDataOe), .busDataOut(busDataOut)
  );
endmodule

// File: tb/xbus_seq_tb.sv
`timescale 1ns/1ps
module xbus_seq_tb;
  localparam int AW = 24, DW = 24, WW = 4;
  localparam logic [DW-1:0] PAT = 24'h5A3C96;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 0, cfgLockHold = 0, reqValid = 0, reqWrite = 0, reqRmw = 0;
  logic [WW-1:0] cfgWait = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic busAck = 0;
  logic reqReady, done, busRdN, busWrN, busDataOe, busLock;
  logic [DW-1:0] rdData, busDataOut, busDataIn;
  logic [AW-1:0] busAddr;

  int checks = 0, fails = 0;
  int lowCnt = 0, ackAfter = 0;
  bit ackForce = 0, finished = 0;

  // reference model state
  int mPhase = 0, mCnt = 0, mWait = 0, mCfgWait = 0;
  bit mAck = 0, mWrite = 0, mRmw = 0, mLock = 0, mDone = 0, mHold = 0;
  logic [AW-1:0] mAddr = '0;
  logic [DW-1:0] mWdata = '0, mRdata = '0;

  always #2 clk = ~clk;

  assign busDataIn = busAddr ^ PAT;

  xbus_seq #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWait(cfgWait),
    .cfgLockHold(cfgLockHold), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqRmw(reqRmw), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .done(done), .rdData(rdData), .busAddr(busAddr),
    .busRdN(busRdN), .busWrN(busWrN), .busDataOe(busDataOe),
    .busDataOut(busDataOut), .busDataIn(busDataIn), .busAck(busAck),
    .busLock(busLock)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every edge
  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mWait = 0; mCfgWait = 0; mAck = 0; mWrite = 0;
      mRmw = 0; mLock = 0; mDone = 0; mHold = 0; mAddr = '0; mWdata = '0;
      mRdata = '0;
    end else begin
      mDone = 0;
      if (mPhase == 0) begin
        if (reqValid) begin
          mPhase = 1; mWait = mCfgWait; mCnt = 0; mAck = 0;
          mRmw = reqRmw; mWrite = reqWrite && !reqRmw; mLock = reqRmw;
          mAddr = reqAddr; mWdata = reqWdata;
        end
      end else if (mPhase == 2) begin
        mPhase = 1; mWrite = 1; mCnt = 0; mAck = 0;
      end else begin
        if (mCnt >= mWait && (mWait == 0 || mAck)) begin
          if (!mWrite) mRdata = mAddr ^ PAT;
          if (mRmw && !mWrite) mPhase = 2;
          else begin mPhase = 0; mDone = 1; mLock = 0; end
        end else begin
          if (mCnt < mWait) mCnt++;
          mAck = mAck | busAck;
        end
      end
      if (cfgWe) begin mCfgWait = int'(cfgWait); mHold = cfgLockHold; end
    end
  end

  // per-clock comparison and acknowledge generation, away from the edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(busRdN == !(mPhase == 1 && !mWrite), "R6 busRdN", busRdN, !(mPhase == 1 && !mWrite));
      chk(busWrN == !(mPhase == 1 && mWrite), "R6 busWrN", busWrN, !(mPhase == 1 && mWrite));
      chk(busDataOe == (mPhase == 1 && mWrite), "R6 busDataOe", busDataOe, (mPhase == 1 && mWrite));
      if (busDataOe) chk(busDataOut == mWdata, "R6 busDataOut", busDataOut, mWdata);
      chk(busAddr == ((mPhase != 0) ? mAddr : '0), "R8 busAddr", busAddr, (mPhase != 0) ? mAddr : '0);
      chk(busLock == (mLock | mHold), "R8 busLock", busLock, mLock | mHold);
      chk(done == mDone, "R7 done", done, mDone);
      if (mDone) chk(rdData == mRdata, "R7 rdData", rdData, mRdata);
      chk(reqReady == (mPhase == 0), "R5 reqReady", reqReady, mPhase == 0);
    end
    if (!busRdN || !busWrN) lowCnt++; else lowCnt = 0;
    busAck = ackForce || (ackAfter > 0 && lowCnt >= ackAfter);
  end

  task automatic setCfg(input int w, input bit hold);
    @(negedge clk);
    cfgWe = 1; cfgWait = WW'(w); cfgLockHold = hold;
    @(negedge clk);
    cfgWe = 0;
  endtask

  // issue one request; returns strobe-low clocks, lock-high clocks, total to done
  task automatic runReq(input bit wr, input bit rmw, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output int lowClk,
                        output int lockClk, output int total,
                        output logic [DW-1:0] rd);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqRmw = rmw; reqAddr = a; reqWdata = d;
    lowClk = 0; lockClk = 0; total = 0;
    @(negedge clk);
    reqValid = 0; reqWrite = 0; reqRmw = 0;
    forever begin
      total++;
      if (!busRdN || !busWrN) lowClk++;
      if (busLock) lockClk++;
      if (done) begin rd = rdData; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    int lw, lk, tot;
    logic [DW-1:0] rd;
    repeat (3) @(negedge clk);
    // R1
    chk(busRdN && busWrN && !busDataOe && !busLock && !done && reqReady && busAddr == '0,
        "R1 reset outputs", {busRdN, busWrN, busDataOe, busLock, done, reqReady}, 6'b110001);
    rstN = 1;
    @(negedge clk);
    // R1: default wait count is zero
    ackForce = 0; ackAfter = 0;
    runReq(0, 0, 24'h000123, '0, lw, lk, tot, rd);
    chk(lw == 1, "R1 default zero wait", lw, 1);
    // R4: zero wait, acknowledge high
    ackForce = 1;
    runReq(0, 0, 24'h0A0B0C, '0, lw, lk, tot, rd);
    chk(lw == 1, "R4 zero wait ack high", lw, 1);
    // R7
    chk(rd == (24'h0A0B0C ^ PAT), "R7 read data", rd, 24'h0A0B0C ^ PAT);
    chk(tot == lw + 1, "R7 done timing", tot, lw + 1);
    // R2
    setCfg(1, 0);
    runReq(1, 0, 24'h111111, 24'hABCDEF, lw, lk, tot, rd);
    chk(lw == 2, "R2 write W1 ack high", lw, 2);
    setCfg(3, 0);
    runReq(0, 0, 24'h222222, '0, lw, lk, tot, rd);
    chk(lw == 4, "R2 read W3 ack high", lw, 4);
    // R2: late-but-earlier-than-wait acknowledge keeps the minimum
    ackForce = 0; setCfg(4, 0); ackAfter = 2;
    runReq(0, 0, 24'h333333, '0, lw, lk, tot, rd);
    chk(lw == 5, "R2 W4 ack at 2", lw, 5);
    // R3
    setCfg(1, 0); ackAfter = 5;
    runReq(1, 0, 24'h444444, 24'h13579B, lw, lk, tot, rd);
    chk(lw == 6, "R3 W1 ack at 5", lw, 6);
    ackAfter = 9;
    runReq(0, 0, 24'h454545, '0, lw, lk, tot, rd);
    chk(lw == 10, "R3 W1 ack at 9", lw, 10);
    chk(rd == (24'h454545 ^ PAT), "R7 stretched read data", rd, 24'h454545 ^ PAT);
    // R4: zero wait, acknowledge never comes
    setCfg(0, 0); ackAfter = 0; ackForce = 0;
    runReq(1, 0, 24'h555555, 24'h2468AC, lw, lk, tot, rd);
    chk(lw == 1, "R4 zero wait no ack", lw, 1);
    // R5: acknowledge while idle, then a cycle that must wait for a fresh one
    setCfg(2, 0); ackForce = 1;
    repeat (4) @(negedge clk);
    chk(busRdN && busWrN && reqReady && !done && !busLock, "R5 idle under ack",
        {busRdN, busWrN, reqReady, done, busLock}, 5'b11100);
    ackForce = 0; ackAfter = 4;
    runReq(0, 0, 24'h666666, '0, lw, lk, tot, rd);
    chk(lw == 5, "R5 stale ack ignored", lw, 5);
    // R8: exchange
    setCfg(1, 0); ackAfter = 0; ackForce = 1;
    runReq(0, 1, 24'h777777, 24'hC0FFEE, lw, lk, tot, rd);
    chk(lw == 4, "R8 rmw strobe clocks", lw, 4);
    chk(lk == 5, "R8 lock span", lk, 5);
    chk(tot == 6, "R8 rmw total", tot, 6);
    chk(rd == (24'h777777 ^ PAT), "R8 rmw read word", rd, 24'h777777 ^ PAT);
    chk(!busLock, "R8 lock low in done clock", busLock, 0);
    // R9
    setCfg(1, 1);
    @(negedge clk);
    chk(busLock, "R9 hold forces lock idle", busLock, 1);
    runReq(1, 0, 24'h888888, 24'h00FF00, lw, lk, tot, rd);
    chk(lk == tot, "R9 hold through cycle", lk, tot);
    setCfg(1, 0);
    @(negedge clk);
    chk(!busLock, "R9 hold released", busLock, 0);
    // R10: configuration change during a cycle
    ackForce = 1;
    @(negedge clk);
    reqValid = 1; reqAddr = 24'h999999; reqWrite = 0;
    @(negedge clk);
    reqValid = 0; cfgWe = 1; cfgWait = 4'd5;
    lw = 0;
    if (!busRdN) lw++;
    @(negedge clk);
    cfgWe = 0;
    while (!done) begin
      if (!busRdN) lw++;
      @(negedge clk);
    end
    chk(lw == 2, "R10 running cycle keeps old wait", lw, 2);
    runReq(0, 0, 24'hAAAAAA, '0, lw, lk, tot, rd);
    chk(lw == 6, "R10 next cycle uses new wait", lw, 6);
    ackForce = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R3 watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule